// File: doc/BRIEF.md
# Pipelined Converter Digital Correction Back End

This block sits behind the comparators of a four-stage pipelined analog-to-digital converter. The first three stages each resolve a coarse code and pass an amplified residue on, so the codes for one sample reach the logic one cycle apart: stage 1 first, stage 4 three cycles later. The block delays the early codes so that the four codes of one sample line up. It then adds them at overlapping binary weights. The overlap is one redundant bit per non-final stage, which lets a coarse comparator error in one stage be absorbed by the next. A fixed bias is removed from the sum and the result is clamped to the 12-bit range.

The corrected word is registered and presented as straight binary, with 0x800 for zero differential input. A select line gives a two's-complement view by flipping only the top bit. An active-high enable drives the data pins; when the enable is low the pins are released to high impedance. A valid flag marks words built entirely from codes presented since reset. A corrupted code only spoils the samples that are in flight at that moment.

Top module: `pipe_adc_correct`

## Requirements
- R1: A synchronous active-low reset clears every alignment and output register. While reset is held, and with the enable high and the select low, the data reads 0x000 and the valid flag is low.
- R2: After reset is released, the valid flag is low after the first three rising edges, goes high after the fourth, and stays high until the next reset.
- R3: The stage 1, 2, 3 and 4 codes of one sample are presented on four consecutive edges, in stage order. The corrected word for that sample appears after the edge that takes the stage 4 code, which is three cycles after the sample edge. A new sample is accepted on every edge.
- R4: The corrected value equals s1*128 + s2*32 + s3*8 + s4 - 84. Here s1 is the 5-bit code, s2 and s3 are the 3-bit codes and s4 is the 4-bit code. For example, codes 3,1,1,1 give 341 and codes 1,0,0,0 give 44.
- R5: Codes 16,2,2,4 give 0x800, and codes 31,6,2,3 give exactly 0xFFF without clamping.
- R6: A sum below 84 reads 0x000 (codes 0,0,0,0 and 0,2,1,3 both give 0x000), and a sum of 85 reads 0x001.
- R7: A sum above 4179 reads 0xFFF (codes 31,6,2,4 and 31,7,7,15 both give 0xFFF).
- R8: With the two's-complement select high, bit 11 of the output is inverted and bits 10..0 are unchanged. The select acts on the held word without waiting for a clock edge: 0x800 reads 0x000, 0x000 reads 0x800 and 0xFFF reads 0x7FF.
- R9: With the enable low, all 12 data pins are undriven, so a pull-up on the net reads 0xFFF. Raising the enable drives the held word again without a clock edge.
- R10: A stage code corrupted for a single cycle changes at most the words in flight. From the fourth edge after the corruption onward, the output again equals the word that clean codes give.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; all registers use its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| code_s1 | input | W1 (5) | Coarse code of stage 1, taken on the sample edge |
| code_s2 | input | W2 (3) | Coarse code of stage 2, one edge after its sample |
| code_s3 | input | W3 (3) | Coarse code of stage 3, two edges after its sample |
| code_s4 | input | W4 (4) | Final flash code, three edges after its sample |
| twos_sel | input | 1 | High selects the two's-complement view |
| out_en | input | 1 | High drives the data pins; low releases them |
| dout | output | OUT_W (12) | Corrected output word, or high impedance |
| dvalid | output | 1 | High when the output word is built from post-reset codes |

## Verification
The bench builds the block with its default split of 5, 3, 3 and 4 code bits. This gives a 12-bit word, stage weights of 128, 32, 8 and 1, and a bias of 84. With this split the raw sum spans 0 to 4263, so both clamp ends can be reached directly from legal codes, and the exact boundary sums of 84, 85 and 4179 can be driven. A pull-up on every data bit in the bench turns the released state into a value the bench can read. A behavioural queue model, fed with the codes actually driven, predicts the data and the valid flag on every edge, including through reset release and a single-cycle code corruption.

// File: rtl/adc_corr_pkg.sv
// Package: shared constants and helpers for the pipelined converter
// correction back end.
// Assumes: four stages, one redundant bit in every non-final stage.
package adc_corr_pkg;

    localparam int NUM_STAGES = 4;
    localparam int PIPE_LAT   = NUM_STAGES - 1;

    // Bias that one redundant stage adds: its weight times a quarter of its code span.
    function automatic int bias_term(input int shift, input int width);
        return (1 << shift) * (1 << (width - 2));
    endfunction

endpackage

// File: rtl/align_delay.sv
// Module: align_delay
// Delays one stage code by DEPTH cycles, so that it meets the codes that
// later stages resolve for the same sample.
// Assumes: DEPTH >= 1; the reset is synchronous and active low and clears
// every tap.
module align_delay #(
    parameter int W     = 5,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam int FILL_W = $clog2(DEPTH + 1);

    logic [W-1:0] tap [DEPTH];

    // First tap: captures the incoming code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap[0] <= '0;
        end else begin
            tap[0] <= din;
        end
    end

    generate
        for (genvar i = 1; i < DEPTH; i++) begin : g_tap
            // Later taps: each moves the code one cycle further along.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tap[i] <= '0;
                end else begin
                    tap[i] <= tap[i-1];
                end
            end
        end
    endgenerate

    assign dout = tap[DEPTH-1];

    // Checker support: counts edges since reset, up to DEPTH.
    logic [FILL_W-1:0] fill;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
        end else if (fill != FILL_W'(DEPTH)) begin
            fill <= fill + 1'b1;
        end
    end

    // R3: once the taps are filled, the output is the input from DEPTH edges ago.
    assert_align_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == FILL_W'(DEPTH)) |-> (dout == $past(din, DEPTH)));

endmodule

// File: rtl/code_merge.sv
// Module: code_merge
// Adds the aligned stage codes at overlapping binary weights, removes the
// redundancy bias and clamps the result to the output range.
// Assumes: the inputs already belong to one sample. The sum is two bits
// wider than the output, which cannot overflow for stages whose codes
// overlap by one bit.
module code_merge #(
    parameter int W1     = 5,
    parameter int W2     = 3,
    parameter int W3     = 3,
    parameter int W4     = 4,
    parameter int OUT_W  = 12,
    parameter int SH1    = 7,
    parameter int SH2    = 5,
    parameter int SH3    = 3,
    parameter int OFFSET = 84
) (
    input  logic [W1-1:0]    s1,
    input  logic [W2-1:0]    s2,
    input  logic [W3-1:0]    s3,
    input  logic [W4-1:0]    s4,
    output logic [OUT_W-1:0] word
);

    localparam int             SUM_W = OUT_W + 2;
    localparam logic [SUM_W-1:0] BIAS  = SUM_W'(OFFSET);
    localparam logic [SUM_W-1:0] TOP   = SUM_W'((1 << OUT_W) - 1);

    logic [SUM_W-1:0] raw;
    logic [SUM_W-1:0] unbiased;

    // Weighted sum of the four stage codes.
    always_comb begin
        raw = (SUM_W'(s1) << SH1) + (SUM_W'(s2) << SH2)
            + (SUM_W'(s3) << SH3) + SUM_W'(s4);
    end

    // Bias removal and clamping to 0 .. 2^OUT_W-1.
    always_comb begin
        unbiased = raw - BIAS;
        if (raw < BIAS) begin
            word = '0;
        end else if (unbiased > TOP) begin
            word = TOP[OUT_W-1:0];
        end else begin
            word = unbiased[OUT_W-1:0];
        end
    end

    // Guards on both clamp ends.
    always_comb begin
        if (raw <= BIAS) begin
            assert_clamp_floor_R6: assert (word == '0);
        end
        if (raw >= BIAS + TOP) begin
            assert_clamp_ceiling_R7: assert (word == TOP[OUT_W-1:0]);
        end
    end

endmodule

// File: rtl/out_stage.sv
// Module: out_stage
// Registers the corrected word, tracks how long fresh samples have been
// flowing since reset, and drives the data pins in the selected format or
// releases them.
// Assumes: LAT >= 1 is the sample-to-merge latency. The pins are released by
// driving high impedance, and the net outside is expected to be resolved.
module out_stage #(
    parameter int OUT_W = 12,
    parameter int LAT   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] word,
    input  logic             twos_sel,
    input  logic             out_en,
    output wire  [OUT_W-1:0] dout,
    output logic             dvalid
);

    logic [OUT_W-1:0] held;
    logic [LAT-1:0]   fresh;
    logic [OUT_W-1:0] shown;

    // Output register for the corrected word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else begin
            held <= word;
        end
    end

    // Marks edges since reset; a word is valid once LAT fresh edges have fed it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh  <= '0;
            dvalid <= 1'b0;
        end else begin
            fresh  <= LAT'((fresh << 1) | LAT'(1));
            dvalid <= fresh[LAT-1];
        end
    end

    // Format view: two's complement flips only the top bit.
    always_comb begin
        shown            = held;
        shown[OUT_W-1]   = held[OUT_W-1] ^ twos_sel;
    end

    assign dout = out_en ? shown : 'z;

    // R1: reset leaves the output register and the valid flag clear.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (held == '0) && !dvalid);

    // R2: once raised, the valid flag stays high until reset.
    assert_valid_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |=> dvalid);

    // R2: the valid flag rises only after LAT edges out of reset.
    assert_valid_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dvalid) |-> $past(rst_n, LAT));

endmodule

// File: rtl/pipe_adc_correct.sv
// Module: pipe_adc_correct
// Digital correction back end of a four-stage pipelined converter. It
// aligns the staggered stage codes, merges them with one-bit overlap,
// clamps the result and presents a registered word.
// Assumes: the stage k code of a sample arrives k-1 edges after the sample
// edge; the reset is synchronous and active low.
module pipe_adc_correct
    import adc_corr_pkg::*;
#(
    parameter int W1    = 5,
    parameter int W2    = 3,
    parameter int W3    = 3,
    parameter int W4    = 4,
    parameter int OUT_W = W1 + W2 + W3 + W4 - (NUM_STAGES - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W1-1:0]    code_s1,
    input  logic [W2-1:0]    code_s2,
    input  logic [W3-1:0]    code_s3,
    input  logic [W4-1:0]    code_s4,
    input  logic             twos_sel,
    input  logic             out_en,
    output wire  [OUT_W-1:0] dout,
    output logic             dvalid
);

    localparam int SH4    = 0;
    localparam int SH3    = SH4 + W4 - 1;
    localparam int SH2    = SH3 + W3 - 1;
    localparam int SH1    = SH2 + W2 - 1;
    localparam int OFFSET = bias_term(SH2, W2) + bias_term(SH3, W3) + bias_term(SH4, W4);

    logic [W1-1:0]    al_s1;
    logic [W2-1:0]    al_s2;
    logic [W3-1:0]    al_s3;
    logic [OUT_W-1:0] merged;

    align_delay #(.W(W1), .DEPTH(PIPE_LAT)) u_al1 (
        .clk (clk), .rst_n (rst_n), .din (code_s1), .dout (al_s1)
    );

    align_delay #(.W(W2), .DEPTH(PIPE_LAT - 1)) u_al2 (
        .clk (clk), .rst_n (rst_n), .din (code_s2), .dout (al_s2)
    );

    align_delay #(.W(W3), .DEPTH(PIPE_LAT - 2)) u_al3 (
        .clk (clk), .rst_n (rst_n), .din (code_s3), .dout (al_s3)
    );

    code_merge #(
        .W1 (W1), .W2 (W2), .W3 (W3), .W4 (W4), .OUT_W (OUT_W),
        .SH1 (SH1), .SH2 (SH2), .SH3 (SH3), .OFFSET (OFFSET)
    ) u_merge (
        .s1 (al_s1), .s2 (al_s2), .s3 (al_s3), .s4 (code_s4), .word (merged)
    );

    out_stage #(.OUT_W(OUT_W), .LAT(PIPE_LAT)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .word     (merged),
        .twos_sel (twos_sel),
        .out_en   (out_en),
        .dout     (dout),
        .dvalid   (dvalid)
    );

endmodule

// File: tb/sim_pipe_adc_correct.sv
module sim_pipe_adc_correct;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] c1 = '0;
    logic [2:0] c2 = '0;
    logic [2:0] c3 = '0;
    logic [3:0] c4 = '0;
    logic       fmt = 1'b0;
    logic       oe = 1'b1;
    wire [11:0] dbus;
    wire        vld;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    done = 1'b0;

    always #2 clk = ~clk;

    for (genvar i = 0; i < 12; i++) begin : g_pu
        pullup (dbus[i]);
    end

    pipe_adc_correct u0 (
        .clk (clk), .rst_n (rst_n),
        .code_s1 (c1), .code_s2 (c2), .code_s3 (c3), .code_s4 (c4),
        .twos_sel (fmt), .out_en (oe), .dout (dbus), .dvalid (vld)
    );

    function automatic int corr(input int a, input int b, input int c, input int d);
        int s;
        s = a * 128 + b * 32 + c * 8 + d - 84;
        if (s < 0) s = 0;
        if (s > 4095) s = 4095;
        return s;
    endfunction

    function automatic int view(input int w, input bit f);
        return f ? (w ^ 2048) : w;
    endfunction

    task automatic check(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    // Behavioural model: queues of driven codes, compared on every edge.
    int q1[$] = '{0, 0, 0};
    int q2[$] = '{0, 0};
    int q3[$] = '{0};
    int mw = 0;
    bit mv = 1'b0;
    int edges = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q1 = '{0, 0, 0};
            q2 = '{0, 0};
            q3 = '{0};
            mw = 0;
            mv = 1'b0;
            edges = 0;
        end else begin
            mw = corr(q1[0], q2[0], q3[0], int'(c4));
            void'(q1.pop_front()); q1.push_back(int'(c1));
            void'(q2.pop_front()); q2.push_back(int'(c2));
            void'(q3.pop_front()); q3.push_back(int'(c3));
            edges++;
            mv = (edges >= 4);
        end
        #1;
        if (!done) begin
            check({tag, " data"}, int'(dbus), oe ? view(mw, fmt) : 32'hFFF);
            check({tag, " valid"}, int'(vld), int'(mv));
        end
    end

    task automatic put(input int a, input int b, input int c, input int d);
        @(negedge clk);
        c1 = 5'(a); c2 = 3'(b); c3 = 3'(c); c4 = 4'(d);
    endtask

    // Holds one code set long enough to fill the pipeline, then samples.
    task automatic settle(input string t, input int a, input int b, input int c,
                          input int d, input int exp);
        repeat (5) put(a, b, c, d);
        @(posedge clk); #1;
        check(t, int'(dbus), exp);
    endtask

    int sa[24], sb[24], sc[24], sd[24];

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) @(negedge clk);
        check("R1 reset data", int'(dbus), 0);
        check("R1 reset valid", int'(vld), 0);

        // R2: valid after the fourth edge out of reset
        tag = "R2";
        rst_n = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(posedge clk); #1;
            check("R2 valid timing", int'(vld), (k >= 4) ? 1 : 0);
        end

        tag = "R4";
        settle("R4 codes 3,1,1,1", 3, 1, 1, 1, 341);
        settle("R4 codes 1,0,0,0", 1, 0, 0, 0, 44);

        tag = "R5";
        settle("R5 mid scale", 16, 2, 2, 4, 12'h800);
        settle("R5 top unclamped", 31, 6, 2, 3, 12'hFFF);

        tag = "R6";
        settle("R6 all zero", 0, 0, 0, 0, 0);
        settle("R6 below bias", 0, 2, 1, 3, 0);
        settle("R6 sum 85", 0, 2, 2, 5, 1);

        tag = "R7";
        settle("R7 just over", 31, 6, 2, 4, 12'hFFF);
        settle("R7 all ones", 31, 7, 7, 15, 12'hFFF);

        // R8: two's-complement view
        tag = "R8";
        fmt = 1'b1;
        settle("R8 mid", 16, 2, 2, 4, 12'h000);
        settle("R8 top", 31, 7, 7, 15, 12'h7FF);
        settle("R8 bottom", 0, 0, 0, 0, 12'h800);
        @(negedge clk); fmt = 1'b0; #1;
        check("R8 select acts at once", int'(dbus), 12'h000);

        // R9: output enable
        tag = "R9";
        settle("R9 driven", 16, 2, 2, 4, 12'h800);
        @(negedge clk); oe = 1'b0; #1;
        check("R9 released", int'(dbus), 12'hFFF);
        @(posedge clk); #1;
        check("R9 stays released", int'(dbus), 12'hFFF);
        @(negedge clk); oe = 1'b1; #1;
        check("R9 driven again", int'(dbus), 12'h800);

        // R3: staggered arrival, one sample per edge
        tag = "R3";
        for (int n = 0; n < 24; n++) begin
            sa[n] = (n * 11 + 5) % 32;
            sb[n] = (n * 5 + 1) % 8;
            sc[n] = (n * 3 + 2) % 8;
            sd[n] = (n * 7 + 4) % 16;
        end
        for (int t = 0; t < 27; t++) begin
            put((t < 24) ? sa[t] : 0,
                (t >= 1 && t < 25) ? sb[t-1] : 0,
                (t >= 2 && t < 26) ? sc[t-2] : 0,
                (t >= 3) ? sd[t-3] : 0);
            @(posedge clk); #1;
            if (t >= 3) begin
                check("R3 aligned sample", int'(dbus),
                      corr(sa[t-3], sb[t-3], sc[t-3], sd[t-3]));
            end
        end

        // R10: recovery from a single corrupted code
        tag = "R10";
        settle("R10 clean", 20, 3, 4, 9, 2613);
        put(20, 0, 4, 9);
        for (int k = 1; k <= 4; k++) begin
            put(20, 3, 4, 9);
        end
        @(posedge clk); #1;
        check("R10 stage 2 upset cleared", int'(dbus), 2613);
        put(5, 3, 4, 9);
        for (int k = 1; k <= 4; k++) begin
            put(20, 3, 4, 9);
        end
        @(posedge clk); #1;
        check("R10 stage 1 upset cleared", int'(dbus), 2613);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule